// File: doc/BRIEF.md
# Single-Clock FIFO with Show-Ahead Output

This block is a synchronous first-in first-out buffer running on a single clock. A producer pushes words with a write request, a consumer pulls them with a read request, and the block reports a full flag, an empty flag and a count of stored words. The storage is a plain register array with no vendor memory.

Two elaboration-time parameters select how the read side behaves. The output mode picks between normal operation, where a word reaches the data output one cycle after the read that asks for it, and show-ahead operation, where the oldest word is already on the output while the buffer reports not empty. The optimization option picks area or speed. Each combination has its own fixed cycle latency for every flag and for the data output. The main effect is that a word written into an empty buffer becomes visible on the empty flag (and in show-ahead mode on the output) later when the speed option or show-ahead is chosen.

A synchronous clear empties the buffer in any mode. The depth is a power of two, and the word count is log2(depth) bits wide.

Top module: `sc_fifo`

## Requirements
- R1: After asynchronous reset, or one cycle after a synchronous clear, empty is 1, full is 0 and used_words is 0. The clear takes priority over any request in the same cycle.
- R2: full is 1 exactly when DEPTH words are stored and changes one cycle after the request that causes it. While full is 1, used_words reads 0, because it holds the count modulo DEPTH.
- R3: A write request while full is 1 is ignored, even if a read arrives in the same cycle. The count and the stored contents stay as they were.
- R4: A read request while empty is 1 is ignored, and the count stays as it was.
- R5: used_words changes one cycle after an accepted write or read. A write and a read accepted in the same cycle leave it unchanged.
- R6: In normal mode, rd_data shows the oldest word one cycle after an accepted read and keeps that value until the next accepted read.
- R7: In show-ahead mode, rd_data shows the oldest stored word whenever empty is 0, and shows the next word one cycle after an accepted read.
- R8: After a write into an empty buffer, empty goes to 0 after 1 + S + A cycles, where S is 1 for the speed option and A is 1 for show-ahead mode. This gives 1 for normal/area, 2 for normal/speed, 2 for show-ahead/area and 3 for show-ahead/speed. In show-ahead mode the word appears on rd_data in the same cycle.
- R9: empty goes to 1 one cycle after the read that takes the last visible word.
- R10: Words leave in the order they were accepted, with no loss and no duplication.
- R11: A read is accepted only while empty is 0. A word whose empty latency has not yet elapsed is counted in used_words but cannot be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclr | input | 1 | Synchronous clear to the empty state |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request |
| wr_data | input | DATA_W | Word to write |
| rd_data | output | DATA_W | Output word |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | No readable word |
| used_words | output | log2(DEPTH) | Stored word count modulo DEPTH |

## Verification
The bound checker tests rules that hold in every cycle whatever the mode:
- the count wraps to zero while full is asserted,
- a blocked write or read leaves the count alone,
- a paired read and write keep the count steady,
- a clear empties the buffer,
- reading the single remaining word raises empty.

Other behaviour needs the bench's scenarios:
- the per-mode latency of empty and of the data output after a write into an empty buffer,
- the ordering of words,
- the refusal to read a word that is still inside its latency window.

The bench runs one instance for each mode and option pair on the same stimulus to compare those latencies.

// File: rtl/sc_fifo_pkg.sv
package sc_fifo_pkg;

    typedef enum logic {
        MODE_NORMAL    = 1'b0,
        MODE_SHOWAHEAD = 1'b1
    } out_mode_e;

    typedef enum logic {
        OPT_AREA  = 1'b0,
        OPT_SPEED = 1'b1
    } opt_e;

    // cycles between an accepted write into an empty buffer and empty falling
    function automatic int unsigned empty_delay(input out_mode_e mode, input opt_e opt);
        int unsigned d;
        d = 1;
        if (opt == OPT_SPEED)
            d = d + 1;
        if (mode == MODE_SHOWAHEAD)
            d = d + 1;
        return d;
    endfunction

endpackage

// File: rtl/sc_fifo_ram.sv
module sc_fifo_ram #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sc_fifo_ctrl.sv
module sc_fifo_ctrl #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclr,
    input  logic          wr_req,
    input  logic          rd_acc,
    output logic          wr_acc,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr_q,
    output logic [AW-1:0] rptr_d,
    output logic [AW-1:0] used_words,
    output logic          full
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          full;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  wr_ok;

    always_comb begin
        st_d  = st_q;
        wr_ok = wr_req && !st_q.full;
        if (wr_ok)
            st_d.wptr = st_q.wptr + AW'(1);
        if (rd_acc)
            st_d.rptr = st_q.rptr + AW'(1);
        case ({wr_ok, rd_acc})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        st_d.full = (st_d.cnt == CW'(DEPTH));
        if (sclr) begin
            st_d  = '0;
            wr_ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign wr_acc     = wr_ok;
    assign wptr       = st_q.wptr;
    assign rptr_q     = st_q.rptr;
    assign rptr_d     = st_d.rptr;
    assign used_words = st_q.cnt[AW-1:0];
    assign full       = st_q.full;

endmodule

// File: rtl/sc_fifo_vis.sv
module sc_fifo_vis #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DELAY = 1,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclr,
    input  logic wr_acc,
    input  logic rd_acc,
    output logic empty
);

    typedef struct packed {
        logic [CW-1:0] vis;
        logic          empty;
    } vis_t;

    localparam vis_t VIS_RST = '{vis: '0, empty: 1'b1};

    vis_t st_q, st_d;
    logic arrive;

    generate
        if (DELAY > 1) begin : g_dly
            logic [DELAY-2:0] pipe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pipe_q <= '0;
                else if (sclr)
                    pipe_q <= '0;
                else
                    pipe_q <= (DELAY-1)'({pipe_q, wr_acc});
            end
            assign arrive = pipe_q[DELAY-2];
        end else begin : g_nodly
            assign arrive = wr_acc;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        case ({arrive, rd_acc})
            2'b10:   st_d.vis = st_q.vis + CW'(1);
            2'b01:   st_d.vis = st_q.vis - CW'(1);
            default: st_d.vis = st_q.vis;
        endcase
        st_d.empty = (st_d.vis == '0);
        if (sclr)
            st_d = VIS_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= VIS_RST;
        else
            st_q <= st_d;
    end

    assign empty = st_q.empty;

endmodule

// File: rtl/sc_fifo.sv
module sc_fifo
    import sc_fifo_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned DEPTH    = 16,
    parameter out_mode_e   OUT_MODE = MODE_SHOWAHEAD,
    parameter opt_e        OPT      = OPT_SPEED,
    localparam int unsigned AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclr,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic [AW-1:0]     used_words
);

    localparam int unsigned EMPTY_DLY = empty_delay(OUT_MODE, OPT);
    localparam bit          SHOW      = (OUT_MODE == MODE_SHOWAHEAD);

    typedef struct packed {
        logic [DATA_W-1:0] q;
    } out_t;

    out_t              out_q, out_d;
    logic              rd_acc;
    logic              wr_acc;
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr_q;
    logic [AW-1:0]     rptr_d;
    logic [AW-1:0]     raddr;
    logic [DATA_W-1:0] ram_rd;

    assign rd_acc = rd_req && !empty;

    sc_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclr       (sclr),
        .wr_req     (wr_req),
        .rd_acc     (rd_acc),
        .wr_acc     (wr_acc),
        .wptr       (wptr),
        .rptr_q     (rptr_q),
        .rptr_d     (rptr_d),
        .used_words (used_words),
        .full       (full)
    );

    sc_fifo_vis #(.DEPTH(DEPTH), .DELAY(EMPTY_DLY)) u_vis (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclr   (sclr),
        .wr_acc (wr_acc),
        .rd_acc (rd_acc),
        .empty  (empty)
    );

    generate
        if (SHOW) begin : g_ahead_addr
            assign raddr = rptr_d;
        end else begin : g_normal_addr
            assign raddr = rptr_q;
        end
    endgenerate

    sc_fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (ram_rd)
    );

    always_comb begin
        out_d = out_q;
        if (sclr)
            out_d.q = '0;
        else if (SHOW || rd_acc)
            out_d.q = ram_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign rd_data = out_q.q;

endmodule

// File: rtl/sc_fifo_chk.sv
module sc_fifo_chk #(
    parameter int unsigned AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sclr,
    input logic          wr_req,
    input logic          rd_req,
    input logic          full,
    input logic          empty,
    input logic [AW-1:0] used_words
);

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sclr |=> (empty && !full && used_words == '0));

    p_full_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (used_words == '0));

    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !rd_req && !sclr) |=> (full && $stable(used_words)));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req && !wr_req && !sclr) |=> $stable(used_words));

    p_pair_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && wr_req && rd_req && !sclr) |=> ($stable(used_words) && !full));

    p_last_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && used_words == AW'(1) && rd_req && !wr_req && !sclr) |=> empty);

endmodule

bind sc_fifo sc_fifo_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclr       (sclr),
    .wr_req     (wr_req),
    .rd_req     (rd_req),
    .full       (full),
    .empty      (empty),
    .used_words (used_words)
);

// File: tb/tb_sc_fifo.sv
module tb_sc_fifo;
    import sc_fifo_pkg::*;

    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int AW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclr = 1'b0;
    logic          wr_req = 1'b0;
    logic          rd_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          full;
    logic          empty;
    logic [AW-1:0] used_words;

    logic [DW-1:0] aux_q     [3];
    logic          aux_full  [3];
    logic          aux_empty [3];
    logic [AW-1:0] aux_used  [3];

    int            checks = 0;
    int            errors = 0;
    int            mcnt   = 0;
    bit            done   = 0;
    logic [DW-1:0] exp_q [$];

    always #10 clk = ~clk;

    sc_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .OUT_MODE(MODE_SHOWAHEAD), .OPT(OPT_SPEED)) dut (
        .clk(clk), .rst_n(rst_n), .sclr(sclr), .wr_req(wr_req), .rd_req(rd_req),
        .wr_data(wr_data), .rd_data(rd_data), .full(full), .empty(empty),
        .used_words(used_words)
    );

    // aux 0: normal/area, 1: normal/speed, 2: show-ahead/area
    for (genvar i = 0; i < 3; i++) begin : g_aux
        localparam out_mode_e M = (i == 2) ? MODE_SHOWAHEAD : MODE_NORMAL;
        localparam opt_e      O = (i == 1) ? OPT_SPEED : OPT_AREA;
        sc_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .OUT_MODE(M), .OPT(O)) u_aux (
            .clk(clk), .rst_n(rst_n), .sclr(sclr), .wr_req(wr_req), .rd_req(rd_req),
            .wr_data(wr_data), .rd_data(aux_q[i]), .full(aux_full[i]),
            .empty(aux_empty[i]), .used_words(aux_used[i])
        );
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // driver: applies one cycle of stimulus and records expected words
    task automatic step(input bit w, input bit r, input logic [DW-1:0] d, input bit c);
        @(posedge clk);
        #1;
        wr_req  = w;
        rd_req  = r;
        wr_data = d;
        sclr    = c;
        if (c)
            exp_q.delete();
        else if (w && !full)
            exp_q.push_back(d);
    endtask

    // monitor: count model and scoreboard on the show-ahead/speed instance
    always @(negedge clk) begin
        if (!rst_n) begin
            mcnt = 0;
        end else begin
            chk(full == (mcnt == DEPTH), "R2", "full vs model", full, mcnt == DEPTH);
            chk(used_words == AW'(mcnt % DEPTH), "R5", "used_words vs model",
                used_words, mcnt % DEPTH);
            if (sclr) begin
                mcnt = 0;
            end else begin
                automatic bit wacc = wr_req && (mcnt != DEPTH);
                automatic bit racc = rd_req && !empty;
                if (racc) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R10", "read with empty scoreboard", rd_data, 0);
                    end else begin
                        chk(rd_data == exp_q[0], "R10", "head word order", rd_data, exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                end
                mcnt = mcnt + int'(wacc) - int'(racc);
            end
        end
    end

    initial begin
        int dly [3];
        dly[0] = 1; dly[1] = 2; dly[2] = 2;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(empty == 1'b1, "R1", "empty in reset", empty, 1);
        chk(full == 1'b0, "R1", "full in reset", full, 0);
        chk(used_words == '0, "R1", "used_words in reset", used_words, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R8 / R7: write into empty, watch each configuration
        step(1, 0, 8'hA5, 0);
        step(0, 0, 8'h00, 0);
        for (int j = 1; j <= 4; j++) begin
            @(negedge clk);
            chk(empty == (j < 3), "R8", $sformatf("sa/speed empty at +%0d", j), empty, j < 3);
            if (j >= 3)
                chk(rd_data == 8'hA5, "R7", "sa/speed head on q", rd_data, 8'hA5);
            for (int k = 0; k < 3; k++)
                chk(aux_empty[k] == (j < dly[k]), "R8",
                    $sformatf("cfg%0d empty at +%0d", k, j), aux_empty[k], j < dly[k]);
            if (j >= 2)
                chk(aux_q[2] == 8'hA5, "R7", "sa/area head on q", aux_q[2], 8'hA5);
        end

        // R6: normal-mode q only after the read edge
        step(0, 1, 8'h00, 0);
        @(negedge clk);
        chk(aux_q[0] == 8'h00, "R6", "normal/area q before read edge", aux_q[0], 0);
        chk(aux_q[1] == 8'h00, "R6", "normal/speed q before read edge", aux_q[1], 0);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(aux_q[0] == 8'hA5, "R6", "normal/area q after read", aux_q[0], 8'hA5);
        chk(aux_q[1] == 8'hA5, "R6", "normal/speed q after read", aux_q[1], 8'hA5);
        chk(empty == 1'b1, "R9", "empty after last read", empty, 1);
        chk(aux_empty[0] == 1'b1, "R9", "normal/area empty after last read", aux_empty[0], 1);
        step(0, 0, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(aux_q[0] == 8'hA5, "R6", "normal q holds", aux_q[0], 8'hA5);

        // R11: read inside the latency window is refused
        step(1, 0, 8'h11, 0);
        step(0, 1, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        repeat (3) step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(used_words == AW'(1), "R11", "early read refused, count", used_words, 1);
        chk(empty == 1'b0, "R11", "word visible later", empty, 0);
        chk(rd_data == 8'h11, "R11", "word on q", rd_data, 8'h11);
        step(0, 1, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(empty == 1'b1, "R9", "empty after read of single word", empty, 1);

        // R4: reads while empty
        step(0, 1, 8'h00, 0);
        step(0, 1, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(used_words == '0, "R4", "count after empty reads", used_words, 0);
        chk(empty == 1'b1, "R4", "still empty", empty, 1);

        // R2 / R3: fill to full, then overflow attempts
        for (int i = 0; i < DEPTH; i++)
            step(1, 0, DW'(8'h20 + i), 0);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(full == 1'b1, "R2", "full after DEPTH writes", full, 1);
        chk(used_words == '0, "R2", "count wraps when full", used_words, 0);
        step(1, 0, 8'hEE, 0);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(full == 1'b1, "R3", "full after ignored write", full, 1);
        step(1, 1, 8'hEF, 0);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(full == 1'b0, "R3", "write with read at full ignored", full, 0);
        chk(used_words == AW'(DEPTH - 1), "R3", "count after read at full",
            used_words, DEPTH - 1);

        // R5: paired read and write
        step(1, 1, 8'h41, 0);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(used_words == AW'(DEPTH - 1), "R5", "paired request keeps count",
            used_words, DEPTH - 1);

        // drain, R9 on last word, R10 through the monitor
        for (int i = 0; i < DEPTH - 1; i++)
            step(0, 1, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(empty == 1'b1, "R9", "empty after drain", empty, 1);
        chk(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);

        // mixed traffic
        for (int i = 0; i < 400; i++)
            step(1'($urandom % 2), 1'($urandom % 2), DW'($urandom), 0);
        for (int i = 0; i < DEPTH + 6; i++)
            step(0, 1, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(exp_q.size() == 0, "R10", "scoreboard empty after traffic", exp_q.size(), 0);

        // R1: synchronous clear with a request in the same cycle
        step(1, 0, 8'h51, 0);
        step(1, 0, 8'h52, 0);
        step(1, 0, 8'h53, 0);
        step(1, 0, 8'h54, 1);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(empty == 1'b1, "R1", "empty after clear", empty, 1);
        chk(full == 1'b0, "R1", "full after clear", full, 0);
        chk(used_words == '0, "R1", "count after clear", used_words, 0);
        step(1, 0, 8'h66, 0);
        repeat (4) step(0, 0, 8'h00, 0);
        step(0, 1, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        @(negedge clk);
        chk(exp_q.size() == 0, "R1", "clean operation after clear", exp_q.size(), 0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule